// File: doc/BRIEF.md
# Frame-Tick Watchdog Timer

This block supervises the embedded processor of a USB serial bridge. It counts 1 ms ticks taken from the USB start-of-frame pulses. It counts only while the device is attached to the bus. If software lets 128 ticks pass without servicing it, the block raises a one-cycle reset request.

Software talks to the block through one 8-bit register. Bit 0 is a write-only service strobe. The disable code is split into two parts: bit 7 and bits 5..1. Bit 6 is a sticky flag that records whether the last reset came from a timeout. The cause flag survives the watchdog reset that the block itself requests. Only the power-on reset clears it.

Top module: `sof_watchdog`

## Requirements
- R1: After power-on reset the read value is 0x80: bit 7 is 1, bits 5..1 are 00000b, the cause flag (bit 6) is 0, bit 0 is 0. The reset request is low.
- R2: While attached and enabled, with no service, the reset request rises after exactly the 128th tick and stays high for one clock cycle. No request follows the 127th tick.
- R3: A tick that arrives while `bus_attached` is low is ignored, and the count is kept.
- R4: A write with bit 0 = 1 restarts the count from zero and wins over a tick in the same cycle. A write with bit 0 = 0 leaves the count unchanged. Bit 0 always reads 0.
- R5: The block is disabled only while bits 5..1 hold 10101b and bit 7 holds 0. Any other pattern, such as 10101b with bit 7 = 1, or 10100b with bit 7 = 0, keeps it running.
- R6: A timeout sets the cause flag (bit 6), and the flag reads 1 in the same cycle as the request.
- R7: Writing 1 to bit 6 clears the cause flag. Writing 0 to bit 6 leaves it set.
- R8: A timeout returns bit 7 to 1 and bits 5..1 to 00000b, and leaves the cause flag set. Only power-on reset clears the flag.
- R9: After a timeout the count restarts from zero, so the next request needs another 128 ticks.
- R10: While disabled the count is held at zero. After re-enabling, a full 128 ticks are needed for a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_attached | input | 1 | High while the device is connected to the USB; gates counting |
| frame_tick | input | 1 | One-cycle pulse per start-of-frame (1 ms) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| reg_rd_data | output | 8 | Register read value |

## Verification
The bench aims at the 127th and 128th ticks. A count that is off by one would fire a tick early or a tick late. It drives a service write in the same cycle as a tick; a design that gave the tick priority would then time out one tick sooner. It writes the almost-right disable codes, with the wrong bit 7 or a single wrong bit in 5..1. A decoder that checks only one of the two fields would stop the timer. It also writes 0 over the cause flag and crosses timeouts with the flag set. A design that cleared the flag on any write, or on its own reset request, would lose the record of why the processor restarted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Register bit positions; software decodes these.
    localparam int SVC_BIT   = 0;
    localparam int CODE_LSB  = 1;
    localparam int CODE_MSB  = 5;
    localparam int CAUSE_BIT = 6;
    localparam int GATE_BIT  = 7;

    localparam int CODE_W = CODE_MSB - CODE_LSB + 1;

    // Pattern that stops the timer.
    localparam logic [CODE_W-1:0] OFF_CODE = 5'b10101;
    localparam logic              OFF_GATE = 1'b0;

    typedef struct packed {
        logic              gate;
        logic              cause;
        logic [CODE_W-1:0] code;
    } wdt_fields_t;

    localparam wdt_fields_t FIELDS_RST = '{gate: 1'b1, cause: 1'b0, code: '0};

endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int TICKS = 128
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick_ok,
    input  logic service,
    input  logic enabled,
    output logic expire,
    output logic req_q
);
    localparam int CNT_W = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        expire   = 1'b0;
        if (!enabled || service) begin
            st_d.cnt = '0;
        end else if (tick_ok) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.req = expire;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q = st_q.req;

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       expire,
    output logic       service,
    output logic       enabled,
    output logic [7:0] rd_data
);
    wdt_fields_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (wr_en) begin
            f_d.gate = wr_data[GATE_BIT];
            f_d.code = wr_data[CODE_MSB:CODE_LSB];
            if (wr_data[CAUSE_BIT]) begin
                f_d.cause = 1'b0;
            end
        end
        // A timeout overrides a same-cycle write.
        if (expire) begin
            f_d.gate  = FIELDS_RST.gate;
            f_d.code  = FIELDS_RST.code;
            f_d.cause = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            f_q <= FIELDS_RST;
        end else begin
            f_q <= f_d;
        end
    end

    assign service = wr_en & wr_data[SVC_BIT];
    assign enabled = !((f_q.code == OFF_CODE) && (f_q.gate == OFF_GATE));

    always_comb begin
        rd_data                     = '0;
        rd_data[GATE_BIT]           = f_q.gate;
        rd_data[CAUSE_BIT]          = f_q.cause;
        rd_data[CODE_MSB:CODE_LSB]  = f_q.code;
        rd_data[SVC_BIT]            = 1'b0;
    end

endmodule

// File: rtl/sof_watchdog.sv
module sof_watchdog #(
    parameter int TICKS = 128
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       bus_attached,
    input  logic       frame_tick,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wr_data,
    output logic       wdt_rst_req,
    output logic [7:0] reg_rd_data
);
    logic tick_ok;
    logic service;
    logic enabled;
    logic expire;

    assign tick_ok = bus_attached & frame_tick;

    wdt_ctrl_reg u_reg (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .expire  (expire),
        .service (service),
        .enabled (enabled),
        .rd_data (reg_rd_data)
    );

    wdt_tick_counter #(.TICKS(TICKS)) u_cnt (
        .clk     (clk),
        .por_n   (por_n),
        .tick_ok (tick_ok),
        .service (service),
        .enabled (enabled),
        .expire  (expire),
        .req_q   (wdt_rst_req)
    );

endmodule

// File: rtl/sof_watchdog_chk.sv
module sof_watchdog_chk (
    input logic       clk,
    input logic       por_n,
    input logic       bus_attached,
    input logic       frame_tick,
    input logic       reg_wr_en,
    input logic [7:0] reg_wr_data,
    input logic       wdt_rst_req,
    input logic [7:0] reg_rd_data
);
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |=> !wdt_rst_req); // R2

    AST_REQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> ($past(bus_attached) && $past(frame_tick))); // R3

    AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> !$past(reg_wr_en && reg_wr_data[0])); // R4

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> !(($past(reg_rd_data[7]) == 1'b0) && ($past(reg_rd_data[5:1]) == 5'b10101))); // R5

    AST_REQ_SETS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> reg_rd_data[6]); // R6

    AST_CAUSE_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reg_rd_data[6]) |-> wdt_rst_req); // R6

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        ($past(reg_rd_data[6]) && !$past(reg_wr_en && reg_wr_data[6])) |-> reg_rd_data[6]); // R7

    AST_TIMEOUT_DEFAULTS: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> (reg_rd_data[7] && (reg_rd_data[5:1] == 5'b00000))); // R8

endmodule

bind sof_watchdog sof_watchdog_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .bus_attached (bus_attached),
    .frame_tick   (frame_tick),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .wdt_rst_req  (wdt_rst_req),
    .reg_rd_data  (reg_rd_data)
);

// File: tb/sof_watchdog_tb.sv
module sof_watchdog_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       bus_attached = 1'b0;
    logic       frame_tick = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic       wdt_rst_req;
    logic [7:0] reg_rd_data;

    always #2 clk = ~clk;

    sof_watchdog u_dut (
        .clk          (clk),
        .por_n        (por_n),
        .bus_attached (bus_attached),
        .frame_tick   (frame_tick),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .wdt_rst_req  (wdt_rst_req),
        .reg_rd_data  (reg_rd_data)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       req;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_cmp  = 0;
    int   n_bad  = 0;
    int   pulses = 0;

    // Monitor: count pulses and compare queued expectations.
    always @(negedge clk) begin
        if (por_n && wdt_rst_req === 1'b1) pulses++;
        if (q.size() > 0) begin
            cur = q.pop_front();
            n_cmp++;
            if (reg_rd_data !== cur.rd || wdt_rst_req !== cur.req) begin
                n_bad++;
                $display("FAIL %s: rd=%02h req=%0b, expected rd=%02h req=%0b",
                         cur.tag, reg_rd_data, wdt_rst_req, cur.rd, cur.req);
            end
        end
    end

    task automatic step(input logic t, input logic w, input logic [7:0] d);
        frame_tick  = t;
        reg_wr_en   = w;
        reg_wr_data = d;
        @(posedge clk);
        #1;
        frame_tick = 1'b0;
        reg_wr_en  = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00);
    endtask

    task automatic expect_out(input string tag, input logic [7:0] rd, input logic req);
        exp_t e;
        e.tag = tag;
        e.rd  = rd;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic check_pulses(input string tag, input int want);
        @(negedge clk);
        #1;
        n_cmp++;
        if (pulses != want) begin
            n_bad++;
            $display("FAIL %s: pulses=%0d, expected %0d", tag, pulses, want);
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        por_n = 1'b1;
        expect_out("R1 reset state", 8'h80, 1'b0);
        @(posedge clk);
        #1;

        // R2: first timeout at exactly the 128th tick
        bus_attached = 1'b1;
        ticks(127);
        expect_out("R2 no request after 127 ticks", 8'h80, 1'b0);
        check_pulses("R2 pulses after 127 ticks", 0);
        step(1'b1, 1'b0, 8'h00);
        expect_out("R2 R6 request at 128th tick", 8'hC0, 1'b1);
        step(1'b0, 1'b0, 8'h00);
        expect_out("R2 request lasts one cycle", 8'hC0, 1'b0);

        // R7: write 0 to the flag keeps it, write 1 clears it
        step(1'b0, 1'b1, 8'h80);
        expect_out("R7 writing 0 keeps flag", 8'hC0, 1'b0);
        step(1'b0, 1'b1, 8'hC0);
        expect_out("R7 writing 1 clears flag", 8'h80, 1'b0);

        // R3 and R9: detached ticks ignored, full window after timeout
        bus_attached = 1'b0;
        ticks(200);
        check_pulses("R3 no count while detached", 1);
        bus_attached = 1'b1;
        ticks(127);
        check_pulses("R9 restart needs full window", 1);
        step(1'b1, 1'b0, 8'h00);
        expect_out("R9 second timeout", 8'hC0, 1'b1);
        step(1'b0, 1'b1, 8'hC0);

        // R4: service wins over same-cycle tick; bit 0 reads 0
        ticks(100);
        step(1'b1, 1'b1, 8'h81);
        expect_out("R4 service bit reads 0", 8'h80, 1'b0);
        ticks(127);
        check_pulses("R4 service restarts count", 2);
        step(1'b1, 1'b0, 8'h00);
        expect_out("R4 timeout after service", 8'hC0, 1'b1);
        step(1'b0, 1'b1, 8'hC0);

        // R4: writing 0 to bit 0 has no effect
        ticks(100);
        step(1'b0, 1'b1, 8'h80);
        ticks(27);
        check_pulses("R4 zero write does not service", 3);
        step(1'b1, 1'b0, 8'h00);
        expect_out("R4 timeout with zero write", 8'hC0, 1'b1);
        step(1'b0, 1'b1, 8'hC0);

        // R5 and R10: disable code, counter held at zero
        ticks(60);
        step(1'b0, 1'b1, 8'h2A);
        expect_out("R5 disable pattern read back", 8'h2A, 1'b0);
        ticks(300);
        check_pulses("R5 disabled makes no request", 4);
        step(1'b0, 1'b1, 8'h80);
        ticks(127);
        check_pulses("R10 full window after re-enable", 4);
        step(1'b1, 1'b0, 8'h00);
        expect_out("R10 timeout after re-enable", 8'hC0, 1'b1);

        // R5: gate bit 1 with the code keeps it running; R8 defaults restored
        step(1'b0, 1'b1, 8'hAA);
        expect_out("R5 partial pattern read back", 8'hEA, 1'b0);
        ticks(127);
        check_pulses("R5 partial pattern still counts", 5);
        step(1'b1, 1'b0, 8'h00);
        expect_out("R8 timeout restores defaults, flag kept", 8'hC0, 1'b1);

        // R5: wrong code bit with gate 0 keeps it running
        step(1'b0, 1'b1, 8'h28);
        ticks(128);
        check_pulses("R5 one-bit-off code still counts", 7);

        // R8: only power-on reset clears the flag
        step(1'b0, 1'b1, 8'h2A);
        expect_out("R8 flag kept across writes", 8'h6A, 1'b0);
        @(posedge clk);
        #1;
        por_n = 1'b0;
        @(posedge clk);
        #1;
        por_n = 1'b1;
        expect_out("R8 R1 power-on clears flag", 8'h80, 1'b0);
        @(posedge clk);
        #1;
        @(posedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule